// File: doc/BRIEF.md
# Missing-Pulse Phase Synchronizer

The block runs on a fast system clock and accepts an external reference stream that has already been converted to a clean digital level. It produces a square-wave PWM-rate reference whose frequency is the external stream divided by 6 or 8. The rising edges of the stream are re-timed through a two-flop synchronizer. The spacing between consecutive rising edges is measured in system cycles, and each edge advances a slot counter.

When the stream has one deliberately omitted pulse per frame, the block treats the first edge after the gap as slot 0 of a new frame, which puts the omitted pulse in the last slot. Once the gap has recurred at a consistent spacing, the block declares lock. The output is then shifted from the frame boundary by a quarter-period step chosen by a 2-bit code, so several blocks that share one stream can be staggered. With no gap in the stream, the block divides by 8 and its phase starts from the first edge it sees. If the gaps stop, it returns to that free-running mode.

Top module: `gap_phase_sync`

## Requirements
- R1: While reset is held and right after it is released, `pwm_ref_o`, `locked_o` and `six_active_o` are all 0.
- R2: While unlocked, the first detected rising edge after reset is slot 0. Every further edge advances the slot modulo 8. `pwm_ref_o` is 1 in slots 0 to 3 and 0 in slots 4 to 7. Each output change appears within 8 system cycles of the external rising edge that causes it.
- R3: While unlocked, `six_sel_i` and `phase_sel_i` have no effect on `pwm_ref_o`, and `six_active_o` stays 0.
- R4: An edge interval counts as a missing pulse only when it is more than 1.5 times the last normal interval. A 1.25x interval is normal and leaves the slot sequence unchanged. A 2x interval realigns the slot counter so that the edge after the gap is slot 0.
- R5: `locked_o` rises on a missing-pulse edge whose spacing from the previous missing-pulse edge is exactly N slots. N is 6 when `six_sel_i`=1 and 8 otherwise, and the omitted slot counts as one slot. With frames of N slots whose last pulse is omitted, this happens on the second gap-following edge.
- R6: A missing-pulse spacing other than N slots does not set lock and clears an existing lock.
- R7: While locked with N=8, `pwm_ref_o` is 1 exactly when ((slot - OFF) mod N) < N/2, with slot 0 being the edge after the gap. OFF is 2, 4, 6 and 0 slots for `phase_sel_i` codes 0, 1, 2 and 3 (90, 180, 270 and 0 degrees).
- R8: While locked with N=6, the same rule applies with OFF of 2, 3, 5 and 0 slots for codes 0 to 3, each rounded to the nearest slot with halves rounded up. `six_active_o` is 1 exactly when locked with N=6.
- R9: Lock clears on the 3N-th consecutive normal edge after the last missing-pulse edge. On that edge the slot advances by one under modulo 8 with zero offset, so the output keeps running with no jump of more than one slot.
- R10: `pwm_ref_o` changes only after a detected rising edge. During an omitted pulse it holds the value of the slot before the gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the external stream |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 1 | Digitized external reference stream, asynchronous to clk |
| six_sel_i | input | 1 | Frame length select: 1 = 6 slots, 0 = 8 slots |
| phase_sel_i | input | 2 | Phase code: 0 = 90, 1 = 180, 2 = 270, 3 = 0 degrees |
| pwm_ref_o | output | 1 | PWM-rate square-wave reference |
| locked_o | output | 1 | Frame phase locked to the missing pulse |
| six_active_o | output | 1 | Locked and running a 6-slot frame |

## Verification
On the edge that first declares lock, three things happen in one cycle: the slot counter realigns to 0, the frame length switches from 8 to the selected value, and the phase offset is applied. The bench provokes this by sampling the very first slot after the second consistent gap, for every code and both lengths, and compares the result with the offset formula. The timeout is a second collision. It clears lock and changes the wrap modulus from 6 to 8 on the same edge that advances the slot. The bench judges it by predicting the slot at that exact edge (6 of 8) and the square wave that follows.

// File: rtl/gps_pkg.sv
package gps_pkg;

    localparam int MAX_SLOTS    = 8;
    localparam int ALT_SLOTS    = 6;
    localparam int QUIET_FRAMES = 3;
    localparam int SLOT_W       = $clog2(MAX_SLOTS + 1);
    localparam int SINCE_W      = $clog2(QUIET_FRAMES * MAX_SLOTS + 3);

    typedef logic [SLOT_W-1:0]  slot_t;
    typedef logic [SINCE_W-1:0] since_t;

    typedef enum logic [1:0] {
        PH_Q1   = 2'd0,
        PH_HALF = 2'd1,
        PH_Q3   = 2'd2,
        PH_NONE = 2'd3
    } phase_code_t;

    typedef struct packed {
        logic edge_hit;
        logic gap_hit;
    } pulse_ev_t;

    typedef struct packed {
        logic   locked;
        logic   hist;
        logic   started;
        slot_t  slot;
        since_t since;
    } frame_st_t;

    function automatic slot_t frame_len(input logic six);
        return six ? slot_t'(ALT_SLOTS) : slot_t'(MAX_SLOTS);
    endfunction

    // quarter-period offset in slots, rounded half up
    function automatic slot_t slot_offset(input phase_code_t code, input slot_t len);
        logic [SLOT_W+2:0] quarters;
        logic [SLOT_W+2:0] prod;
        case (code)
            PH_Q1:   quarters = (SLOT_W+3)'(1);
            PH_HALF: quarters = (SLOT_W+3)'(2);
            PH_Q3:   quarters = (SLOT_W+3)'(3);
            default: quarters = '0;
        endcase
        prod = quarters * (SLOT_W+3)'(len) + (SLOT_W+3)'(2);
        return slot_t'(prod >> 2);
    endfunction

    function automatic logic in_high_half(input slot_t slot, input slot_t off, input slot_t len);
        logic [SLOT_W:0] pos;
        pos = {1'b0, slot} + {1'b0, len} - {1'b0, off};
        if (pos >= {1'b0, len})
            pos = pos - {1'b0, len};
        return ({pos, 1'b0} < {2'b00, len});
    endfunction

endpackage

// File: rtl/gps_pulse_meter.sv
module gps_pulse_meter
    import gps_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ext_i,
    output pulse_ev_t ev_o
);

    logic             meta_q, sync_q, prev_q, seen_q;
    logic [CNT_W-1:0] cnt_q, ref_q;
    logic             rise, long_gap;
    logic [CNT_W+1:0] twice, thrice;

    always_comb begin
        rise        = sync_q & ~prev_q;
        twice       = {1'b0, cnt_q, 1'b0};
        thrice      = {2'b00, ref_q} + {1'b0, ref_q, 1'b0};
        long_gap    = seen_q && (ref_q != '0) && (twice > thrice);
        ev_o.edge_hit = rise;
        ev_o.gap_hit  = rise & long_gap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
            seen_q <= 1'b0;
            cnt_q  <= '0;
            ref_q  <= '0;
        end else begin
            meta_q <= ext_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
            if (rise) begin
                cnt_q  <= CNT_W'(1);
                seen_q <= 1'b1;
                if (seen_q && !long_gap)
                    ref_q <= cnt_q;
            end else if (cnt_q != '1) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // R4
    gap_ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ev_o.gap_hit |=> $stable(ref_q));

endmodule

// File: rtl/gps_framer.sv
module gps_framer
    import gps_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pulse_ev_t   ev_i,
    input  logic        six_i,
    input  phase_code_t phase_i,
    output logic        pwm_o,
    output logic        locked_o,
    output logic        six_o
);

    frame_st_t        st_q, st_d;
    logic             pwm_q, pwm_d, six_q, six_d;
    slot_t            sel_len, run_len, new_off;
    logic [SINCE_W:0] spacing, since_inc, quiet_lim;

    always_comb begin
        sel_len   = frame_len(six_i);
        spacing   = {1'b0, st_q.since} + (SINCE_W+1)'(2);
        since_inc = {1'b0, st_q.since} + (SINCE_W+1)'(1);
        quiet_lim = (SINCE_W+1)'(QUIET_FRAMES) * (SINCE_W+1)'(sel_len);
        st_d      = st_q;
        pwm_d     = pwm_q;
        six_d     = six_q;
        run_len   = slot_t'(MAX_SLOTS);
        new_off   = '0;
        if (ev_i.edge_hit) begin
            if (ev_i.gap_hit) begin
                st_d.locked = st_q.hist && (spacing == (SINCE_W+1)'(sel_len));
                st_d.hist   = 1'b1;
                st_d.since  = '0;
                st_d.slot   = '0;
            end else begin
                if (st_q.since != '1)
                    st_d.since = st_q.since + since_t'(1);
                if (since_inc >= quiet_lim) begin
                    st_d.locked = 1'b0;
                    st_d.hist   = 1'b0;
                end
                run_len = st_d.locked ? sel_len : slot_t'(MAX_SLOTS);
                if (!st_q.started || (st_q.slot + slot_t'(1) >= run_len))
                    st_d.slot = '0;
                else
                    st_d.slot = st_q.slot + slot_t'(1);
            end
            st_d.started = 1'b1;
            run_len = st_d.locked ? sel_len : slot_t'(MAX_SLOTS);
            new_off = st_d.locked ? slot_offset(phase_i, sel_len) : slot_t'(0);
            pwm_d   = in_high_half(st_d.slot, new_off, run_len);
            six_d   = st_d.locked & six_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            pwm_q <= 1'b0;
            six_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            pwm_q <= pwm_d;
            six_q <= six_d;
        end
    end

    assign pwm_o    = pwm_q;
    assign locked_o = st_q.locked;
    assign six_o    = six_q;

    // R5
    lock_rise_on_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.locked) |-> $past(ev_i.gap_hit));

    // R9
    lock_fall_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.locked) |-> $past(ev_i.edge_hit));

    // R10
    pwm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ev_i.edge_hit |=> $stable(pwm_q));

    // R8
    six_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        six_q |-> st_q.locked);

endmodule

// File: rtl/gap_phase_sync.sv
module gap_phase_sync
    import gps_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_clk_i,
    input  logic       six_sel_i,
    input  logic [1:0] phase_sel_i,
    output logic       pwm_ref_o,
    output logic       locked_o,
    output logic       six_active_o
);

    pulse_ev_t ev;

    gps_pulse_meter #(.CNT_W(CNT_W)) u_meter (
        .clk   (clk),
        .rst   (rst),
        .ext_i (ext_clk_i),
        .ev_o  (ev)
    );

    gps_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .ev_i     (ev),
        .six_i    (six_sel_i),
        .phase_i  (phase_code_t'(phase_sel_i)),
        .pwm_o    (pwm_ref_o),
        .locked_o (locked_o),
        .six_o    (six_active_o)
    );

endmodule

// File: tb/gap_phase_sync_tb.sv
module gap_phase_sync_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HIGH_N     = 8;
    localparam int SLOT_N     = 16;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext = 1'b0;
    logic       six = 1'b0;
    logic [1:0] code = 2'd0;
    logic       pwm, lock, six_act;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic s_pwm, s_lock, s_six, g_pwm;

    gap_phase_sync u_dut (
        .clk          (clk),
        .rst          (rst),
        .ext_clk_i    (ext),
        .six_sel_i    (six),
        .phase_sel_i  (code),
        .pwm_ref_o    (pwm),
        .locked_o     (lock),
        .six_active_o (six_act)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_hi(input int slot, input int off, input int len);
        return (((slot + len - off) % len) * 2 < len) ? 1 : 0;
    endfunction

    function automatic int offs(input int c, input int len);
        int q;
        q = (c == 3) ? 0 : c + 1;
        return (q * len + 2) / 4;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        ext = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // one high phase, then low_n cycles low; samples mid-high and mid-gap
    task automatic pulse(input int low_n);
        ext = 1'b1;
        repeat (HIGH_N) @(negedge clk);
        s_pwm  = pwm;
        s_lock = lock;
        s_six  = six_act;
        ext = 1'b0;
        if (low_n > SLOT_N) begin
            repeat (SLOT_N) @(negedge clk);
            g_pwm = pwm;
            repeat (low_n - SLOT_N) @(negedge clk);
        end else begin
            repeat (low_n) @(negedge clk);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 pwm in reset", pwm, 0);
        chk("R1 lock in reset", lock, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pwm after reset", pwm, 0);
        chk("R1 lock after reset", lock, 0);
        chk("R1 six flag after reset", six_act, 0);
    endtask

    task automatic test_free_run();
        do_reset();
        six  = 1'b1;
        code = 2'd1;
        for (int j = 0; j < 12; j++) begin
            pulse(HIGH_N);
            chk("R2 free-run divide by 8", s_pwm, (j % 8) < 4);
            chk("R3 unlocked ignores selects", s_lock, 0);
            chk("R3 six flag stays low", s_six, 0);
            if (j == 5) code = 2'd2;
        end
        pulse(12);                     // edge 12, then a 1.25x interval
        chk("R2 slot 12", s_pwm, 0);
        pulse(HIGH_N);                 // edge 13, still normal
        chk("R4 1.25x interval is normal", s_pwm, 0);
        pulse(HIGH_N);                 // edge 14
        chk("R4 sequence continues", s_pwm, 0);
        pulse(24);                     // edge 15, then a 2x gap
        chk("R2 slot 15", s_pwm, 0);
        chk("R10 pwm held across gap", g_pwm, 0);
        for (int k = 0; k < 5; k++) begin
            pulse(HIGH_N);
            chk("R4 realign after 2x gap", s_pwm, (k % 8) < 4);
        end
    endtask

    task automatic test_lock(input bit six_v, input int code_v);
        int n, off;
        string rq;
        do_reset();
        six  = six_v;
        code = 2'(code_v);
        n    = six_v ? 6 : 8;
        off  = offs(code_v, n);
        rq   = six_v ? "R8" : "R7";
        repeat (3) pulse(HIGH_N);
        for (int f = 0; f < 5; f++) begin
            for (int s = 0; s < n - 1; s++) begin
                pulse((s == n - 2) ? 24 : HIGH_N);
                if (f == 1) chk("R5 not yet locked", s_lock, 0);
                if (f >= 2) begin
                    chk("R5 locked after two gaps", s_lock, 1);
                    chk({rq, " phase offset"}, s_pwm, exp_hi(s, off, n));
                    chk("R8 six flag", s_six, int'(six_v));
                    if (s == n - 2)
                        chk("R10 hold in missing slot", g_pwm, exp_hi(s, off, n));
                end
            end
        end
    endtask

    task automatic test_no_lock();
        do_reset();
        six = 1'b1;
        repeat (3) pulse(HIGH_N);
        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < 7; s++) pulse((s == 6) ? 24 : HIGH_N);
            chk("R6 spacing 8 with N=6", lock, 0);
        end
        do_reset();
        six = 1'b0;
        repeat (3) pulse(HIGH_N);
        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < 6; s++) pulse((s == 5) ? 24 : HIGH_N);
            chk("R6 spacing 7 with N=8", lock, 0);
        end
    endtask

    task automatic test_unlock();
        do_reset();
        six  = 1'b1;
        code = 2'd0;
        repeat (3) pulse(HIGH_N);
        for (int f = 0; f < 3; f++)
            for (int s = 0; s < 5; s++) pulse((s == 4) ? 24 : HIGH_N);
        for (int k = 0; k < 34; k++) begin
            pulse(HIGH_N);
            if (k < 18) begin
                chk("R9 lock held", s_lock, 1);
                chk("R9 locked pattern", s_pwm, exp_hi(k % 6, 2, 6));
            end else begin
                chk("R9 lock dropped", s_lock, 0);
                chk("R9 free pattern after drop", s_pwm, ((6 + k - 18) % 8) < 4);
            end
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        test_reset();
        test_free_run();
        for (int c = 0; c < 4; c++) test_lock(1'b0, c);
        for (int c = 0; c < 4; c++) test_lock(1'b1, c);
        test_no_lock();
        test_unlock();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule